// File: doc/BRIEF.md
# Common Interrupt Distributor

This block takes a set of shared, level-sensitive interrupt inputs and routes each one to the interrupt lines of a small group of cores. Every shared interrupt has its own configuration: a destination core set, a distribution policy and a mask bit. A single command port writes these settings one interrupt at a time. A global enable command opens the unit. Until that command arrives, no line is driven.

Two distribution policies exist. With fixed delivery, the interrupt goes to one core, the lowest one present in its destination set. With rotation, each fresh request goes to the next core in the destination set after the core that was served last. That core then keeps the request until the input drops.

The outputs form a flat vector with one line per shared interrupt per core. They are registered, so they change one clock edge after the state that produces them.

Top module: `cirq_router`

## Requirements
- R1: After reset all outputs are low, every interrupt is masked, every destination set is empty, the unit is disabled, and the rotation pointer of every interrupt sits on the highest-numbered core.
- R2: Nothing is delivered until a command with opcode 4 (enable) has been accepted. The data bits of that command are ignored.
- R3: Opcode 1 writes `cmd_data[N_CORE-1:0]` as the destination set of interrupt `cmd_irq`. Bit c stands for core c.
- R4: Opcode 2 writes the policy of interrupt `cmd_irq` from `cmd_data[1:0]`: 0 selects rotation, and 1, 2 and 3 all select fixed delivery. Bit 4 marks level triggering. All other data bits are ignored.
- R5: Under fixed delivery, an enabled, unmasked, high interrupt drives only the core given by the lowest set bit of its destination set.
- R6: Under rotation, when an interrupt is high, open and not held by any core, it is granted to the first core in its destination set after the core served last, wrapping from the highest core to core 0.
- R7: Under rotation, the granted core keeps the interrupt while the input stays high, even if the destination set is rewritten. Taking the input low releases the grant.
- R8: Opcode 3 masks interrupt `cmd_irq` when `cmd_data[0]` is 1 and unmasks it when that bit is 0. A masked interrupt drives no core and does not move its rotation pointer. A grant held across a mask period returns to the same core on unmask.
- R9: An empty destination set delivers the interrupt to no core, and the rotation pointer does not move.
- R10: Output line `irq_out[i*N_CORE+c]` carries interrupt i to core c. At most one core is driven per interrupt. An input change appears on the outputs at the next clock edge, and a command appears at the edge after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Opcode: 1 destination, 2 policy, 3 mask, 4 enable, others none |
| cmd_irq | input | $clog2(N_IRQ) | Index of the interrupt that the command configures |
| cmd_data | input | DATA_W | Command data |
| irq_in | input | N_IRQ | Shared level interrupt inputs |
| irq_out | output | N_IRQ*N_CORE | Per-core delivery lines, index i*N_CORE+c |

## Verification
A change on `irq_in` is due on `irq_out` one edge later. A command is due two edges later: the first edge stores it in the configuration registers, and the second edge registers the output that the new configuration produces. The bench drives on falling edges. The command task spans the storing edge, so the next falling-edge step after any stimulus covers exactly the edge where the result lands, and every check samples there. The bench works out rotation order from its own copy of the last-served core for each interrupt. That copy advances only on grants the requirements allow, which exposes any skipped or extra rotation step at the first check that follows.

// File: rtl/cirq_pkg.sv
// Package: shared opcode and mode-field definitions for the common
// interrupt distributor. Assumes a 3-bit opcode field on the command port.
package cirq_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_SET_DEST = 3'd1,
        OP_SET_MODE = 3'd2,
        OP_SET_MASK = 3'd3,
        OP_ENABLE   = 3'd4
    } cirq_op_e;

    localparam int POLICY_LSB = 0;
    localparam int POLICY_W   = 2;
    localparam int LEVEL_BIT  = 4;
    localparam int MODE_MIN_W = LEVEL_BIT + 1;

endpackage

// File: rtl/cirq_cfg_regs.sv
// Module: configuration store. Decodes commands into a per-interrupt
// destination set, rotation flag and mask bit, plus one global enable.
// Assumes DATA_W covers both N_CORE and the mode field. Commands naming an
// interrupt index at or above N_IRQ are dropped.
module cirq_cfg_regs
    import cirq_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int N_CORE = 4,
    parameter int DATA_W = 8,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_valid,
    input  logic [2:0]                        cmd_op,
    input  logic [IDX_W-1:0]                  cmd_irq,
    input  logic [DATA_W-1:0]                 cmd_data,
    output logic                              en_o,
    output logic [N_IRQ-1:0]                  mask_o,
    output logic [N_IRQ-1:0]                  rr_o,
    output logic [N_IRQ-1:0][N_CORE-1:0]      dest_o
);

    logic                         en_q;
    logic [N_IRQ-1:0]             mask_q;
    logic [N_IRQ-1:0]             rr_q;
    logic [N_IRQ-1:0][N_CORE-1:0] dest_q;
    logic                         idx_ok;

    // Purpose: reject commands that name a non-existent interrupt.
    always_comb idx_ok = (int'(cmd_irq) < N_IRQ);

    // Purpose: apply one accepted command per cycle to the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= '1;
            rr_q   <= '1;
            dest_q <= '0;
        end else if (cmd_valid) begin
            case (cirq_op_e'(cmd_op))
                OP_SET_DEST: if (idx_ok) dest_q[cmd_irq] <= cmd_data[N_CORE-1:0];
                OP_SET_MODE: if (idx_ok)
                    rr_q[cmd_irq] <= (cmd_data[POLICY_LSB +: POLICY_W] == '0);
                OP_SET_MASK: if (idx_ok) mask_q[cmd_irq] <= cmd_data[0];
                OP_ENABLE:   en_q <= 1'b1;
                default:     ;
            endcase
        end
    end

    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign rr_o   = rr_q;
    assign dest_o = dest_q;

endmodule

// File: rtl/cirq_channel.sv
// Module: distribution logic for one shared interrupt. Holds the current
// rotation grant and the last-served core, and registers the per-core
// output lines. Assumes a level input and N_CORE >= 2.
module cirq_channel #(
    parameter int N_CORE = 4,
    localparam int CW    = $clog2(N_CORE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              mask_i,
    input  logic              rr_i,
    input  logic [N_CORE-1:0] dest_i,
    input  logic              req_i,
    output logic [N_CORE-1:0] out_o
);

    logic [N_CORE-1:0] owner_q, owner_n;
    logic [CW-1:0]     last_q, last_n;
    logic [N_CORE-1:0] out_q, out_n;
    logic [N_CORE-1:0] low_hot;
    logic [N_CORE-1:0] nxt_hot;
    logic [CW-1:0]     nxt_idx;
    logic              open_w;

    // Purpose: one-hot of the lowest set destination bit (fixed delivery).
    always_comb begin
        low_hot = '0;
        for (int c = N_CORE - 1; c >= 0; c--) begin
            if (dest_i[c]) begin
                low_hot    = '0;
                low_hot[c] = 1'b1;
            end
        end
    end

    // Purpose: first destination core after the last served one, wrapping.
    always_comb begin
        logic found;
        found   = 1'b0;
        nxt_hot = '0;
        nxt_idx = last_q;
        for (int k = 1; k <= N_CORE; k++) begin
            int j;
            j = (int'(last_q) + k) % N_CORE;
            if (!found && dest_i[j]) begin
                found      = 1'b1;
                nxt_hot[j] = 1'b1;
                nxt_idx    = CW'(j);
            end
        end
    end

    // Purpose: grant bookkeeping and next output value.
    always_comb begin
        open_w  = en_i && !mask_i;
        owner_n = owner_q;
        last_n  = last_q;
        if (!rr_i || !req_i) begin
            owner_n = '0;
        end else if (owner_q == '0 && open_w && dest_i != '0) begin
            owner_n = nxt_hot;
            last_n  = nxt_idx;
        end
        out_n = (open_w && req_i) ? (rr_i ? owner_n : low_hot) : '0;
    end

    // Purpose: state and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            last_q  <= CW'(N_CORE - 1);
            out_q   <= '0;
        end else begin
            owner_q <= owner_n;
            last_q  <= last_n;
            out_q   <= out_n;
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/cirq_router.sv
// Module: top of the common interrupt distributor. A configuration store
// feeds one distribution channel per shared interrupt; the channel outputs
// are packed as irq_out[i*N_CORE+c]. Assumes N_IRQ >= 2, N_CORE >= 2 and
// DATA_W >= max(N_CORE, 5).
module cirq_router
    import cirq_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int N_CORE = 4,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(N_IRQ),
    localparam int OUT_W = N_IRQ * N_CORE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_irq,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [N_IRQ-1:0]  irq_in,
    output logic [OUT_W-1:0]  irq_out
);

    logic                         en_w;
    logic [N_IRQ-1:0]             mask_w;
    logic [N_IRQ-1:0]             rr_w;
    logic [N_IRQ-1:0][N_CORE-1:0] dest_w;
    logic                         unused_data;

    // Purpose: mark command data bits that no opcode decodes.
    assign unused_data = ^cmd_data;

    cirq_cfg_regs #(
        .N_IRQ  (N_IRQ),
        .N_CORE (N_CORE),
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_irq   (cmd_irq),
        .cmd_data  (cmd_data),
        .en_o      (en_w),
        .mask_o    (mask_w),
        .rr_o      (rr_w),
        .dest_o    (dest_w)
    );

    for (genvar i = 0; i < N_IRQ; i++) begin : g_chan
        logic [N_CORE-1:0] ch_out;
        cirq_channel #(.N_CORE(N_CORE)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (en_w),
            .mask_i (mask_w[i]),
            .rr_i   (rr_w[i]),
            .dest_i (dest_w[i]),
            .req_i  (irq_in[i]),
            .out_o  (ch_out)
        );
        assign irq_out[i*N_CORE +: N_CORE] = ch_out;
    end

endmodule

// File: rtl/cirq_router_chk.sv
// Module: assertion checker bound to cirq_router. Observes the ports plus
// the enable and mask state driven by the configuration store.
module cirq_router_chk #(
    parameter int N_IRQ  = 8,
    parameter int N_CORE = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_IRQ-1:0]          irq_in,
    input logic [N_IRQ*N_CORE-1:0]   irq_out,
    input logic                      en_w,
    input logic [N_IRQ-1:0]          mask_w
);

    // R2
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w |=> irq_out == '0);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        // R10
        single_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(irq_out[i*N_CORE +: N_CORE]));

        // R10
        low_input_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_in[i] |=> irq_out[i*N_CORE +: N_CORE] == '0);

        // R8
        masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mask_w[i] |=> irq_out[i*N_CORE +: N_CORE] == '0);
    end

endmodule

bind cirq_router cirq_router_chk #(
    .N_IRQ  (N_IRQ),
    .N_CORE (N_CORE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .irq_out (irq_out),
    .en_w    (en_w),
    .mask_w  (mask_w)
);

// File: tb/cirq_router_test.sv
// Bench: sweeps destination sets and policies over every interrupt of the
// default configuration and predicts outputs arithmetically.
module cirq_router_test;

    localparam int NI = 8;
    localparam int NC = 4;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [2:0]        cmd_irq = '0;
    logic [DW-1:0]     cmd_data = '0;
    logic [NI-1:0]     irq_in = '0;
    logic [NI*NC-1:0]  irq_out;

    int tests = 0;
    int fails = 0;
    int last_srv [NI];

    always #2 clk = ~clk;

    cirq_router #(.N_IRQ(NI), .N_CORE(NC), .DATA_W(DW)) uut (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_irq (cmd_irq), .cmd_data (cmd_data), .irq_in (irq_in),
        .irq_out (irq_out)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [NI*NC-1:0] exp);
        tests++;
        if (irq_out !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, irq_out, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input int irq, input logic [DW-1:0] data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_irq   = 3'(irq);
        cmd_data  = data;
        step();
        cmd_valid = 1'b0;
        cmd_op    = '0;
    endtask

    function automatic logic [NI*NC-1:0] slice(input int irq, input int core);
        logic [NI*NC-1:0] v;
        v = '0;
        if (core >= 0) v[irq*NC + core] = 1'b1;
        return v;
    endfunction

    function automatic int lowest(input int d);
        for (int c = 0; c < NC; c++) if (d[c]) return c;
        return -1;
    endfunction

    function automatic int next_core(input int last, input int d);
        for (int k = 1; k <= NC; k++) begin
            int j;
            j = (last + k) % NC;
            if (d[j]) return j;
        end
        return -1;
    endfunction

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NI; i++) last_srv[i] = NC - 1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 reset outputs", '0);

        // R1: masked by default; R2: unmasked but not yet enabled
        irq_in = '1;
        step();
        check("R1 masked after reset", '0);
        for (int i = 0; i < NI; i++) begin
            cmd(3'd3, i, 8'h00);
            cmd(3'd1, i, 8'h0F);
            cmd(3'd2, i, 8'h11);
        end
        step();
        check("R2 no delivery before enable", '0);
        cmd(3'd4, 0, 8'h00);
        step();
        begin
            logic [NI*NC-1:0] e;
            e = '0;
            for (int i = 0; i < NI; i++) e |= slice(i, 0);
            check("R2 R5 enabled fixed to core 0", e);
        end
        irq_in = '0;
        step();
        check("R10 inputs low release", '0);

        // R3 R5 R9: fixed delivery sweep over every destination set
        for (int i = 0; i < NI; i++) begin
            for (int d = 0; d < (1 << NC); d++) begin
                cmd(3'd1, i, DW'(d));
                irq_in[i] = 1'b1;
                step();
                check(d == 0 ? "R9 empty set fixed" : "R3 R5 fixed lowest core",
                      slice(i, lowest(d)));
                irq_in[i] = 1'b0;
                step();
                check("R10 low input one edge later", '0);
            end
        end

        // R4: policy codes 1..3 are fixed; unused bits ignored
        for (int m = 1; m < 4; m++) begin
            cmd(3'd2, 2, DW'(m) | 8'hEC);
            cmd(3'd1, 2, 8'h0A);
            irq_in[2] = 1'b1;
            step();
            check("R4 nonzero policy is fixed", slice(2, 1));
            step();
            check("R4 fixed stays on same core", slice(2, 1));
            irq_in[2] = 1'b0;
            step();
        end

        // R6 R7 R9: rotation sweep
        for (int i = 0; i < NI; i++) begin
            cmd(3'd2, i, 8'h10);
            for (int d = 0; d < (1 << NC); d++) begin
                cmd(3'd1, i, DW'(d));
                for (int p = 0; p < 5; p++) begin
                    int n;
                    n = next_core(last_srv[i], d);
                    if (n >= 0) last_srv[i] = n;
                    irq_in[i] = 1'b1;
                    step();
                    check(d == 0 ? "R9 empty set rotation" : "R6 rotation grant", slice(i, n));
                    step();
                    check("R7 grant held", slice(i, n));
                    irq_in[i] = 1'b0;
                    step();
                    check("R7 release on low", '0);
                end
            end
        end

        // R7: grant survives a destination rewrite
        begin
            int n;
            cmd(3'd1, 0, 8'h0F);
            n = next_core(last_srv[0], 15);
            last_srv[0] = n;
            irq_in[0] = 1'b1;
            step();
            check("R7 grant before rewrite", slice(0, n));
            cmd(3'd1, 0, DW'(4'hF & ~(1 << n)));
            step();
            check("R7 grant after rewrite", slice(0, n));
            irq_in[0] = 1'b0;
            step();
            cmd(3'd1, 0, 8'h0F);
        end

        // R8: masked pulses do not rotate; held grant returns after unmask
        begin
            int n;
            cmd(3'd1, 1, 8'h0F);
            cmd(3'd3, 1, 8'h01);
            for (int p = 0; p < 3; p++) begin
                irq_in[1] = 1'b1;
                step();
                check("R8 masked delivers nothing", '0);
                irq_in[1] = 1'b0;
                step();
            end
            cmd(3'd3, 1, 8'hFE);
            n = next_core(last_srv[1], 15);
            last_srv[1] = n;
            irq_in[1] = 1'b1;
            step();
            check("R8 unmasked rotation not advanced", slice(1, n));
            cmd(3'd3, 1, 8'h01);
            step();
            check("R8 mask while held", '0);
            cmd(3'd3, 1, 8'h00);
            step();
            check("R8 held grant returns", slice(1, n));
            irq_in[1] = 1'b0;
            step();
        end

        // R10: simultaneous interrupts with independent fixed targets
        begin
            logic [NI*NC-1:0] e;
            e = '0;
            for (int i = 0; i < NI; i++) begin
                cmd(3'd2, i, 8'h01);
                cmd(3'd1, i, DW'(1 << (i % NC)));
                e |= slice(i, i % NC);
            end
            irq_in = '1;
            step();
            check("R10 line packing", e);
            irq_in = '0;
            step();
            check("R10 all released", '0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule